// File: doc/BRIEF.md
# Digit-Nibble Field Move and Compare Engine

This block runs byte-serial operations on two multi-byte fields held in a byte-wide memory. Only the low (digit) nibble of each byte counts. The upper (zone) nibble is ignored. A caller gives four things:

- the address of the rightmost byte of each operand;
- an encoded length equal to the byte count minus one;
- an operation select;
- a start pulse.

Each field occupies the given number of bytes and runs from its rightmost address toward lower addresses.

**Move.** A move copies digit nibbles from the source field (operand B) into the destination field (operand A). It works from the rightmost byte leftward. Each destination byte is read back before it is written, so its zone nibble survives.

**Compare.** A compare reads both fields as decimal numbers, most significant digit in the leftmost byte, and reports the ordering. It scans from the leftmost byte and stops at the first digit that differs. It never writes memory.

**Result.** Both operations finish with a one-cycle `done` pulse and a 2-bit condition code. The code holds until the next operation finishes.

**Memory port.** The block drives one memory port. Read data is expected on `memRdata` in the cycle after the cycle in which `memRe` is high. A write takes effect at the clock edge where `memWe` is high.

Top module: `fieldq_engine`

## Requirements
- R1: While and after reset, `busy`, `done` and `cc` are 0 and neither `memRe` nor `memWe` is asserted.
- R2: After a move, each destination byte at distance j (j < count) from the destination's rightmost address holds its own former upper nibble above the low nibble of the source byte at distance j. Destination bytes outside the field and all source bytes are unchanged.
- R3: A move issues exactly one write per byte. The first write goes to the destination's rightmost address, and each later write goes to the address one lower than the previous write.
- R4: After a move, `cc` is 0 when every source low nibble in the field is zero, and 1 otherwise. Source upper nibbles play no part.
- R5: A compare never asserts `memWe`, so both operands are left unchanged.
- R6: After a compare, `cc` is 1 when operand A is lower, 2 when the operands are equal and 3 when A is higher. The ordering is by low nibbles read as a decimal number whose leftmost byte is most significant. Upper nibbles are ignored.
- R7: A compare reads byte pairs from the left and stops at the first unequal digit pair. It issues 2·(k+1) reads when the first difference is at position k from the left, and 2·count reads when the fields are equal.
- R8: `lenField` encodes count − 1. `lenField` = 0 processes exactly one byte on either operation.
- R9: `start` is accepted only while `busy` is low. `busy` rises in the next cycle and stays high until the cycle in which `done` pulses for one cycle, where `busy` is already low. A `start` while busy has no effect, and no memory access occurs while idle.
- R10: `cc` changes only in a cycle in which `done` is high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (sampled while idle) |
| opMove | input | 1 | 1 = move B digits into A, 0 = compare A with B |
| addrA | input | ADDR_W | Rightmost byte address of operand A (destination on move) |
| addrB | input | ADDR_W | Rightmost byte address of operand B (source on move) |
| lenField | input | LEN_W | Byte count minus one |
| memRdata | input | 2·DIGIT_W | Read data, valid the cycle after `memRe` |
| memAddr | output | ADDR_W | Memory address |
| memRe | output | 1 | Memory read request |
| memWe | output | 1 | Memory write enable |
| memWdata | output | 2·DIGIT_W | Memory write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code |

## Verification
The assertions take three things for granted:

- the memory returns read data exactly one cycle after each request;
- the caller keeps the operands and length steady only at the start cycle, since the block latches them there;
- consecutive moves are separated by the idle cycles the handshake implies, so a write three cycles before another always belongs to the same move.

The bench stays within these conditions in four ways. Its memory model has a fixed one-cycle read latency. It changes inputs only at the falling edge. It launches each operation from idle. It places the fields so that neither field wraps below address zero.

// File: rtl/fieldq_pkg.sv
package fieldq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_FIN
  } fqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic rdFirst;
    logic rdSecond;
    logic latch1;
    logic wrDst;
    logic advance;
    logic finish;
  } fqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic isMove;
    logic isLast;
    logic digitNeq;
  } fqStatus_t;

  localparam logic [1:0] CC_ZERO = 2'd0;
  localparam logic [1:0] CC_NZ   = 2'd1;
  localparam logic [1:0] CC_LOW  = 2'd1;
  localparam logic [1:0] CC_EQ   = 2'd2;
  localparam logic [1:0] CC_HIGH = 2'd3;

endpackage

// File: rtl/fieldq_ctrl.sv
module fieldq_ctrl
  import fieldq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  fqStatus_t status,
  output fqStrobe_t strobe,
  output logic      busy
);

  fqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  logic lastStep;
  assign lastStep = status.isLast || (!status.isMove && status.digitNeq);

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_RD1;
        end
      end
      ST_RD1: begin
        strobe.rdFirst = 1'b1;
        nextState      = ST_RD2;
      end
      ST_RD2: begin
        strobe.rdSecond = 1'b1;
        strobe.latch1   = 1'b1;
        nextState       = ST_FIN;
      end
      ST_FIN: begin
        strobe.wrDst = status.isMove;
        if (lastStep) begin
          strobe.finish = 1'b1;
          nextState     = ST_IDLE;
        end else begin
          strobe.advance = 1'b1;
          nextState      = ST_RD1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/fieldq_datapath.sv
module fieldq_datapath
  import fieldq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 8,
  parameter int DIGIT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fqStrobe_t             strobe,
  input  logic                  opMove,
  input  logic [ADDR_W-1:0]     addrA,
  input  logic [ADDR_W-1:0]     addrB,
  input  logic [LEN_W-1:0]      lenField,
  input  logic [2*DIGIT_W-1:0]  memRdata,
  output fqStatus_t             status,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memRe,
  output logic                  memWe,
  output logic [2*DIGIT_W-1:0]  memWdata,
  output logic [1:0]            cc,
  output logic                  done
);

  localparam int BYTE_W = 2 * DIGIT_W;

  logic                isMoveR;
  logic [ADDR_W-1:0]   baseA, baseB;
  logic [LEN_W-1:0]    lenR, idx;
  logic [DIGIT_W-1:0]  digit1;
  logic                nzAcc;
  logic [1:0]          ccR;
  logic                doneR;

  // move walks right to left, compare walks left to right
  logic [LEN_W-1:0]  offset;
  logic [ADDR_W-1:0] addrOpA, addrOpB, firstAddr, secondAddr;

  assign offset     = isMoveR ? idx : (lenR - idx);
  assign addrOpA    = baseA - ADDR_W'(offset);
  assign addrOpB    = baseB - ADDR_W'(offset);
  assign firstAddr  = isMoveR ? addrOpB : addrOpA;
  assign secondAddr = isMoveR ? addrOpA : addrOpB;

  logic [DIGIT_W-1:0] digit2;
  logic               digit1Nz;
  assign digit2   = memRdata[DIGIT_W-1:0];
  assign digit1Nz = (digit1 != '0);

  assign memRe    = strobe.rdFirst | strobe.rdSecond;
  assign memWe    = strobe.wrDst;
  assign memAddr  = strobe.rdFirst ? firstAddr
                  : ((strobe.rdSecond | strobe.wrDst) ? secondAddr : '0);
  assign memWdata = {memRdata[BYTE_W-1:DIGIT_W], digit1};

  assign status.isMove   = isMoveR;
  assign status.isLast   = (idx == lenR);
  assign status.digitNeq = (digit1 != digit2);

  always_ff @(posedge clk) begin
    if (rst) begin
      isMoveR <= 1'b0;
      baseA   <= '0;
      baseB   <= '0;
      lenR    <= '0;
      idx     <= '0;
      digit1  <= '0;
      nzAcc   <= 1'b0;
      ccR     <= CC_ZERO;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (strobe.load) begin
        isMoveR <= opMove;
        baseA   <= addrA;
        baseB   <= addrB;
        lenR    <= lenField;
        idx     <= '0;
        nzAcc   <= 1'b0;
      end
      if (strobe.latch1) digit1 <= memRdata[DIGIT_W-1:0];
      if (strobe.advance) begin
        idx   <= idx + 1'b1;
        nzAcc <= nzAcc | (isMoveR & digit1Nz);
      end
      if (strobe.finish) begin
        doneR <= 1'b1;
        if (isMoveR)
          ccR <= (nzAcc | digit1Nz) ? CC_NZ : CC_ZERO;
        else if (digit1 == digit2)
          ccR <= CC_EQ;
        else
          ccR <= (digit1 < digit2) ? CC_LOW : CC_HIGH;
      end
    end
  end

  assign cc   = ccR;
  assign done = doneR;

endmodule

// File: rtl/fieldq_engine.sv
module fieldq_engine
  import fieldq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 8,
  parameter int DIGIT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 opMove,
  input  logic [ADDR_W-1:0]    addrA,
  input  logic [ADDR_W-1:0]    addrB,
  input  logic [LEN_W-1:0]     lenField,
  input  logic [2*DIGIT_W-1:0] memRdata,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 memRe,
  output logic                 memWe,
  output logic [2*DIGIT_W-1:0] memWdata,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           cc
);

  fqStrobe_t strobe;
  fqStatus_t status;
  logic      opMoveLat;

  fieldq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .status (status),
    .strobe (strobe),
    .busy   (busy)
  );

  fieldq_datapath #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .DIGIT_W (DIGIT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opMove   (opMove),
    .addrA    (addrA),
    .addrB    (addrB),
    .lenField (lenField),
    .memRdata (memRdata),
    .status   (status),
    .memAddr  (memAddr),
    .memRe    (memRe),
    .memWe    (memWe),
    .memWdata (memWdata),
    .cc       (cc),
    .done     (done)
  );

  assign opMoveLat = status.isMove;

endmodule

// File: rtl/fieldq_engine_chk.sv
module fieldq_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [1:0]        cc,
  input logic              memRe,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              opMoveLat
);

  // R3
  move_write_order_chk: assert property (@(posedge clk) disable iff (rst)
    (memWe && $past(memWe, 3)) |-> (memAddr == $past(memAddr, 3) - 1'b1));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !opMoveLat) |-> !memWe);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  busy_end_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!memRe && !memWe));

  // R10
  cc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cc) |-> done);

endmodule

bind fieldq_engine fieldq_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .cc        (cc),
  .memRe     (memRe),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .opMoveLat (opMoveLat)
);

// File: tb/fieldq_engine_bench.sv
`timescale 1ns/1ps
module fieldq_engine_bench;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              opMove = 1'b0;
  logic [ADDR_W-1:0] addrA = '0;
  logic [ADDR_W-1:0] addrB = '0;
  logic [LEN_W-1:0]  lenField = '0;
  logic [7:0]        memRdata = '0;
  logic [ADDR_W-1:0] memAddr;
  logic              memRe, memWe;
  logic [7:0]        memWdata;
  logic              busy, done;
  logic [1:0]        cc;

  always #2 clk = ~clk;

  fieldq_engine u_fieldq_engine (
    .clk(clk), .rst(rst), .start(start), .opMove(opMove),
    .addrA(addrA), .addrB(addrB), .lenField(lenField),
    .memRdata(memRdata), .memAddr(memAddr), .memRe(memRe),
    .memWe(memWe), .memWdata(memWdata), .busy(busy),
    .done(done), .cc(cc)
  );

  logic [7:0] mem [0:255];
  int rdCount = 0;
  int wrN = 0;
  int wrLog [0:15];
  int doneCnt = 0;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[7:0]] <= memWdata;
      if (wrN < 16) wrLog[wrN] = int'(memAddr[7:0]);
      wrN++;
    end
    if (memRe) begin
      memRdata <= mem[memAddr[7:0]];
      rdCount++;
    end
  end

  always @(negedge clk) if (done) doneCnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // launch one operation; optionally poke start while busy
  task automatic runOp(input bit mv, input int a, input int b, input int len, input bit poke);
    @(negedge clk);
    rdCount = 0; wrN = 0; doneCnt = 0;
    opMove = mv; addrA = ADDR_W'(a); addrB = ADDR_W'(b);
    lenField = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; opMove = ~mv; lenField = LEN_W'(len + 3);
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 300 && !done; t++) @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R9 done with busy low", int'({done, busy}), 2);
    @(negedge clk);
    @(negedge clk);
    check(doneCnt == 1 && busy == 1'b0, "R9 single done pulse", doneCnt, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 0 && cc == 0, "R1 reset outputs", int'({busy, done, cc}), 0);
    check(memRe == 0 && memWe == 0, "R1 reset memory idle", int'({memRe, memWe}), 0);
    rst = 1'b0;
    @(negedge clk);

    // move sweep: counts 1..4, twenty digit patterns each
    for (int cnt = 1; cnt <= 4; cnt++) begin
      for (int p = 0; p < 20; p++) begin
        logic [7:0] dstOrig [0:5];
        logic [7:0] srcOrig [0:4];
        bit anyNz;
        bool_ok_loop: begin end
        anyNz = 0;
        for (int j = 0; j < 5; j++) begin
          logic [3:0] dg;
          dg = (p == 0) ? 4'd0 : 4'((p * 7 + j * 3) % 16);
          mem[8'h47 - j] = {4'((p + j * 5 + 1) % 16), dg};
          srcOrig[j] = mem[8'h47 - j];
          if (j < cnt && dg != 0) anyNz = 1;
        end
        for (int j = -1; j < 5; j++) begin
          mem[8'h87 - j] = 8'((p * 29 + j * 13 + cnt) % 256);
          dstOrig[j + 1] = mem[8'h87 - j];
        end
        runOp(1'b1, 'h87, 'h47, cnt - 1, (p == 5));
        for (int j = 0; j < 5; j++) begin
          logic [7:0] exp;
          exp = (j < cnt) ? {dstOrig[j + 1][7:4], srcOrig[j][3:0]} : dstOrig[j + 1];
          check(mem[8'h87 - j] == exp, (cnt == 1) ? "R8 one-byte move" : "R2 move byte",
                int'(mem[8'h87 - j]), int'(exp));
          check(mem[8'h47 - j] == srcOrig[j], "R2 source unchanged",
                int'(mem[8'h47 - j]), int'(srcOrig[j]));
        end
        check(mem[8'h88] == dstOrig[0], "R2 right neighbour unchanged", int'(mem[8'h88]), int'(dstOrig[0]));
        check(wrN == cnt, "R3 write count", wrN, cnt);
        for (int j = 0; j < cnt; j++)
          check(wrLog[j] == 'h87 - j, "R3 write order", wrLog[j], 'h87 - j);
        check(cc == (anyNz ? 2'd1 : 2'd0), "R4 move cc", int'(cc), anyNz ? 1 : 0);
      end
    end

    // compare sweep: two-byte fields, digits 0..6 each, varied zones
    for (int a0 = 0; a0 < 7; a0++)
      for (int a1 = 0; a1 < 7; a1++)
        for (int b0 = 0; b0 < 7; b0++)
          for (int b1 = 0; b1 < 7; b1++) begin
            int va, vb, expCc, expRd;
            mem[8'h26] = {4'((a1 + b0 * 3) % 16), 4'(a0)};
            mem[8'h27] = {4'((a0 * 5 + b1) % 16), 4'(a1)};
            mem[8'h36] = {4'((b1 * 7 + 2) % 16), 4'(b0)};
            mem[8'h37] = {4'((a1 * 3 + b0 + 9) % 16), 4'(b1)};
            va = a0 * 10 + a1;
            vb = b0 * 10 + b1;
            expCc = (va < vb) ? 1 : ((va == vb) ? 2 : 3);
            expRd = (a0 != b0) ? 2 : 4;
            runOp(1'b0, 'h27, 'h37, 1, 1'b0);
            check(int'(cc) == expCc, "R6 compare cc", int'(cc), expCc);
            check(rdCount == expRd, "R7 compare read count", rdCount, expRd);
            check(wrN == 0 && mem[8'h26][3:0] == 4'(a0) && mem[8'h37][3:0] == 4'(b1),
                  "R5 compare leaves memory", wrN, 0);
          end

    // one-byte compares (lenField = 0), zones deliberately opposite
    for (int x = 0; x < 10; x++)
      for (int y = 0; y < 10; y++) begin
        int expCc;
        mem[8'h50] = {4'hF, 4'(x)};
        mem[8'h60] = {4'h0, 4'(y)};
        expCc = (x < y) ? 1 : ((x == y) ? 2 : 3);
        runOp(1'b0, 'h50, 'h60, 0, 1'b0);
        check(int'(cc) == expCc, "R8 one-byte compare cc", int'(cc), expCc);
        check(rdCount == 2, "R8 one-byte compare reads", rdCount, 2);
      end

    // four-byte compares: equal, and difference only in the last digit
    for (int j = 0; j < 4; j++) begin
      mem[8'h73 - j] = {4'(j), 4'(j + 3)};
      mem[8'h93 - j] = {4'(j + 8), 4'(j + 3)};
    end
    runOp(1'b0, 'h73, 'h93, 3, 1'b0);
    check(cc == 2'd2, "R6 four-byte equal", int'(cc), 2);
    check(rdCount == 8, "R7 full scan when equal", rdCount, 8);
    mem[8'h93] = {4'h1, 4'd2};
    runOp(1'b0, 'h73, 'h93, 3, 1'b1);
    check(cc == 2'd3, "R6 last digit decides", int'(cc), 3);

    // cc holds while the next operation runs
    @(negedge clk);
    opMove = 1'b1; addrA = 'hA3; addrB = 'hB3; lenField = 3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      check(cc == 2'd3, "R10 cc held while busy", int'(cc), 3);
    end
    for (int t = 0; t < 300 && !done; t++) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule